// File: doc/BRIEF.md
# Memory-Synchronised CPU Clock Generator

This block derives the processor clock from a 16 MHz master clock and places its edges in fixed relation to the DRAM row-strobe slots. One slot is eight master cycles, which is one period of a 2 MHz clock. Every processor access starts with a falling edge of the processor clock on a slot boundary. An access to ROM takes one slot: four cycles low, then four high, so the clock runs at 2 MHz. An access to RAM takes two slots: a full slot low, then a full slot high, so the clock is stretched to 1 MHz. The stretch gives the memory sequencer room to serve its own fetch before the processor's half of the transfer.

The block also produces two timing strobes. The address strobe marks the cycle in which the processor's address and read/write line can be captured. It comes three master cycles after the falling edge, because the processor's address settles late. The data strobe marks the cycle in which write data is taken and read data is presented. It comes three master cycles after the rising edge. A single region-select input tells the block whether the next access goes to RAM or to ROM. Address decoding happens outside the block.

Top module: `cpu_clk_gen`

## Requirements
- R1: An access whose latched type is ROM holds `phi_out` low for 4 master cycles and then high for 4, a period of 8 cycles.
- R2: An access whose latched type is RAM holds `phi_out` low for 8 master cycles and then high for 8, a period of 16 cycles.
- R3: `ram_sel` (1 = RAM, 0 = ROM) is sampled only at the clock edge that ends the last master cycle of an access, and the sampled value sets the type of the next access. Its value in every other cycle has no effect.
- R4: `slot_start` is high in exactly one master cycle out of every 8. Every falling edge of `phi_out` falls in a cycle where `slot_start` is high.
- R5: `addr_stb` is a one-cycle pulse in cycle index 3 of each access, counting the first low cycle as index 0. It occurs exactly once per access.
- R6: `data_stb` is a one-cycle pulse 3 master cycles after the rising edge of `phi_out`: index 7 for ROM and index 11 for RAM. It occurs exactly once per access.
- R7: While `rst` is high, `phi_out`, `addr_stb` and `data_stb` are low and `slot_start` is high. The first access after reset is a ROM access, whatever `ram_sel` is.
- R8: No high or low phase of `phi_out` lasts fewer than 4 master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_sel | input | 1 | Region type of the next access: 1 = RAM, 0 = ROM |
| phi_out | output | 1 | Processor clock |
| addr_stb | output | 1 | Address/read-write capture strobe, one cycle |
| data_stb | output | 1 | Data transfer strobe, one cycle |
| slot_start | output | 1 | High in the first master cycle of each 8-cycle row-strobe slot |

## Verification
The assertions assume that `ram_sel` is synchronous to `clk` and settles before each edge. They make no assumption about when `ram_sel` changes, because any change outside the last cycle of an access must be ignored. The assertions also assume that reset lasts at least one edge, since the phase counters start from reset. The stimulus changes `ram_sel` only at falling edges of `clk`. It deliberately flips `ram_sel` to the wrong value in the middle of some accesses and restores it in the final cycle. The run covers ROM-only, RAM-only and alternating sequences, and a reset applied in the middle of a RAM access while `ram_sel` is held high.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  // Master cycles in one row-strobe slot (one 2 MHz period).
  function automatic int unsigned slot_len(input int unsigned half);
    return 2 * half;
  endfunction

  // Length of the low phase of phi for an access of the given type.
  function automatic int unsigned low_len(input logic ram, input int unsigned half);
    return ram ? 2 * half : half;
  endfunction

  // Total master cycles taken by one access of the given type.
  function automatic int unsigned access_len(input logic ram, input int unsigned half);
    return ram ? 4 * half : 2 * half;
  endfunction

endpackage

// File: rtl/ccg_slot_timer.sv
module ccg_slot_timer #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic slot_start
);
  localparam int unsigned SLOT = ccg_pkg::slot_len(HALF);
  localparam int unsigned SW   = $clog2(SLOT);

  logic [SW-1:0] slot_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
    end else if (slot_cnt == SW'(SLOT - 1)) begin
      slot_cnt <= '0;
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  assign slot_start = (slot_cnt == '0);
endmodule

// File: rtl/ccg_phase_seq.sv
module ccg_phase_seq #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ram_sel,
  output logic is_ram,
  output logic phi_out,
  output logic acc_start,
  output logic acc_end,
  output logic rise_pt
);
  localparam int unsigned CW = $clog2(4 * HALF);

  logic [CW-1:0] acc_cnt;
  logic [CW-1:0] len_m1;
  logic [CW-1:0] low_cnt;

  always_comb begin
    len_m1    = CW'(ccg_pkg::access_len(is_ram, HALF) - 1);
    low_cnt   = CW'(ccg_pkg::low_len(is_ram, HALF));
    acc_start = (acc_cnt == '0);
    acc_end   = (acc_cnt == len_m1);
    rise_pt   = (acc_cnt == low_cnt);
    phi_out   = (acc_cnt >= low_cnt);
  end

  // The access type is latched only when an access closes.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      is_ram  <= 1'b0;
    end else if (acc_end) begin
      acc_cnt <= '0;
      is_ram  <= ram_sel;
    end else begin
      acc_cnt <= acc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccg_strobe_delay.sv
module ccg_strobe_delay #(
  parameter int unsigned DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  logic [DLY-1:0] sr;

  generate
    if (DLY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= trig;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DLY-2:0], trig};
      end
    end
  endgenerate

  assign pulse = sr[DLY-1];
endmodule

// File: rtl/cpu_clk_gen.sv
module cpu_clk_gen #(
  parameter int unsigned HALF    = 4,
  parameter int unsigned STB_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ram_sel,
  output logic phi_out,
  output logic addr_stb,
  output logic data_stb,
  output logic slot_start
);
  // Named internal events, visible to the bound checker.
  logic is_ram;
  logic acc_start;
  logic acc_end;
  logic rise_pt;

  ccg_slot_timer #(.HALF(HALF)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start)
  );

  ccg_phase_seq #(.HALF(HALF)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ram_sel   (ram_sel),
    .is_ram    (is_ram),
    .phi_out   (phi_out),
    .acc_start (acc_start),
    .acc_end   (acc_end),
    .rise_pt   (rise_pt)
  );

  // Address strobe trails the falling edge; data strobe trails the rising edge.
  ccg_strobe_delay #(.DLY(STB_DLY)) u_addr_dly (
    .clk   (clk),
    .rst   (rst),
    .trig  (acc_start),
    .pulse (addr_stb)
  );

  ccg_strobe_delay #(.DLY(STB_DLY)) u_data_dly (
    .clk   (clk),
    .rst   (rst),
    .trig  (rise_pt),
    .pulse (data_stb)
  );
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker #(
  parameter int unsigned HALF    = 4,
  parameter int unsigned STB_DLY = 3
) (
  input logic clk,
  input logic rst,
  input logic ram_sel,
  input logic phi_out,
  input logic addr_stb,
  input logic data_stb,
  input logic slot_start,
  input logic is_ram,
  input logic acc_start,
  input logic acc_end
);
  logic [7:0] pos_q, pos_now;
  logic [7:0] run_q, run_now;
  logic       phi_q;

  assign pos_now = acc_start ? 8'd0 : pos_q + 8'd1;
  assign run_now = (phi_out != phi_q) ? 8'd0 : ((run_q == 8'hFF) ? run_q : run_q + 8'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 8'd0;
      run_q <= 8'(HALF);
      phi_q <= 1'b0;
    end else begin
      pos_q <= pos_now;
      run_q <= run_now;
      phi_q <= phi_out;
    end
  end

  p_sel_latched_r3: assert property (@(posedge clk) disable iff (rst)
    acc_end |=> (is_ram == $past(ram_sel)));

  p_sel_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (is_ram != $past(is_ram)) |-> $past(acc_end));

  p_fall_on_slot_r4: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> (slot_start && !phi_out));

  p_slot_single_r4: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> !slot_start);

  p_addr_pos_r5: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> (!phi_out && pos_now == 8'(STB_DLY)));

  p_data_pos_r6: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> (phi_out && pos_now == (is_ram ? 8'(2 * HALF + STB_DLY) : 8'(HALF + STB_DLY))));

  p_min_phase_r8: assert property (@(posedge clk) disable iff (rst)
    (phi_out != phi_q) |-> (run_q >= 8'(HALF - 1)));
endmodule

bind cpu_clk_gen ccg_checker #(.HALF(HALF), .STB_DLY(STB_DLY)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ram_sel    (ram_sel),
  .phi_out    (phi_out),
  .addr_stb   (addr_stb),
  .data_stb   (data_stb),
  .slot_start (slot_start),
  .is_ram     (is_ram),
  .acc_start  (acc_start),
  .acc_end    (acc_end)
);

// File: tb/cpu_clk_gen_tb.sv
module cpu_clk_gen_tb;
  localparam int H   = 4;
  localparam int STB = 3;
  localparam int SL  = 2 * H;
  localparam int NV  = 10;
  // Entry i gives the type of the access after access i (1 = RAM).
  localparam bit [NV-1:0] SEL_V = 10'b1010010110;
  // Entry i flips ram_sel to the wrong value inside access i (R3).
  localparam bit [NV-1:0] GL_V  = 10'b0101010010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ram_sel = 1'b0;
  logic phi_out, addr_stb, data_stb, slot_start;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  cpu_clk_gen #(.HALF(H), .STB_DLY(STB)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ram_sel    (ram_sel),
    .phi_out    (phi_out),
    .addr_stb   (addr_stb),
    .data_stb   (data_stb),
    .slot_start (slot_start)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Walks one access sample by sample; starts at the negedge showing index 0.
  task automatic do_access(input bit cur, input bit nxt, input bit gl, input string ptag);
    int len  = cur ? 4 * H : 2 * H;
    int lowl = cur ? 2 * H : H;
    for (int idx = 0; idx < len; idx++) begin
      if (idx == 0)       ram_sel = gl ? !nxt : nxt;
      if (idx == len - 1) ram_sel = nxt;
      chk(ptag, phi_out, idx >= lowl);
      chk("R5 addr_stb", addr_stb, idx == STB);
      chk("R6 data_stb", data_stb, idx == lowl + STB);
      chk("R4 slot_start", slot_start, (idx % SL) == 0);
      @(negedge clk);
    end
  endtask

  initial begin
    bit cur;
    bit prev_gl;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 phi_out", phi_out, 1'b0);
    chk("R7 addr_stb", addr_stb, 1'b0);
    chk("R7 data_stb", data_stb, 1'b0);
    chk("R7 slot_start", slot_start, 1'b1);
    rst = 1'b0;

    cur = 1'b0;
    prev_gl = 1'b0;
    for (int i = 0; i < NV; i++) begin
      do_access(cur, SEL_V[i], GL_V[i],
                prev_gl ? "R3 phi_out" : (cur ? "R2 phi_out" : "R1 phi_out"));
      prev_gl = GL_V[i];
      cur = SEL_V[i];
    end
    // Last table access is RAM; follow with one RAM access, then reset inside it.
    do_access(cur, 1'b1, 1'b0, prev_gl ? "R3 phi_out" : (cur ? "R2 phi_out" : "R1 phi_out"));
    repeat (5) @(negedge clk);
    rst = 1'b1;
    ram_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 phi_out", phi_out, 1'b0);
    chk("R7 addr_stb", addr_stb, 1'b0);
    chk("R7 data_stb", data_stb, 1'b0);
    chk("R7 slot_start", slot_start, 1'b1);
    rst = 1'b0;
    // R7: first access after reset is ROM even with ram_sel high.
    do_access(1'b0, 1'b1, 1'b0, "R7 phi_out");
    do_access(1'b1, 1'b0, 1'b0, "R2 phi_out");
    do_access(1'b0, 1'b0, 1'b0, "R1 phi_out");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule